// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block receives bytes from a host over a write-only serial link. The link has an active-low chip select, a serial clock and a data line, plus a separate select line that marks each byte as a command or as display data. All four link lines are brought into a fast system clock through synchronizers. Rising serial clock edges are found inside the system clock domain, and each byte is assembled most significant bit first.

When the eighth bit of a byte arrives, the block latches the select line and sends the byte downstream on a one-cycle strobe, tagged as command or data. It does not decode commands and has no read path. Raising chip select part-way through a byte, or pulling the reset low, throws away the partial byte and rearms the receiver for a new bit 7.

Top module: `serial_byte_rx`

## Requirements
- R1: The data line is sampled on each rising serial clock edge while chip select is low. The first bit of a byte lands in bit 7 of `byte_data` and the eighth bit lands in bit 0.
- R2: While `link_cs_n` is high, serial clock edges have no effect. No byte is emitted, and the next byte after chip select falls starts at bit 7.
- R3: `byte_is_data` is 0 for a command byte and 1 for a display data byte. It takes the level of `link_sel`.
- R4: `link_sel` is sampled only on the eighth rising edge of a byte. Its level during the first seven edges has no effect on the tag.
- R5: If chip select stays low after a byte completes, the next rising edge is bit 7 of a new byte. Back-to-back bytes are each delivered.
- R6: If chip select rises before the eighth edge, the partial byte is discarded. The following byte is received whole and unshifted.
- R7: Driving `rst_n` low aborts a byte in progress and nothing is delivered for it. If chip select is still low after release, the next rising edge is bit 7.
- R8: `byte_valid` is high for exactly one system clock cycle per completed byte. This holds when the system clock runs at least 4 times faster than the serial clock.
- R9: While reset is applied, `rst_n` is sampled on `clk` and held low for at least one cycle. At the first cycle after release, `byte_valid`, `byte_data` and `byte_is_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| link_cs_n | input | 1 | Active-low link chip select |
| link_sck | input | 1 | Serial clock; data sampled on its rising edge |
| link_sdi | input | 1 | Serial data, MSB first |
| link_sel | input | 1 | Byte kind: 0 command, 1 display data |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte |
| byte_is_data | output | 1 | Tag of the received byte |

## Verification
The main function is driven with asymmetric bytes such as 0x01, 0x80 and 0xA5, which separate MSB-first from LSB-first assembly, and with both select levels. One byte changes the select level between the seventh and eighth edges, which separates sampling at the eighth edge from sampling at the start of the byte. Back-to-back bytes under one chip select check that framing continues across byte boundaries. Aborted bytes are checked both by raising chip select and by applying reset. In those cases the byte that follows must arrive unshifted and be the only one delivered, which shows that the bit counter was rearmed.

// File: rtl/sbr_pkg.sv
// Shared constants for the serial byte receiver.
// Assumes: bytes are 8 bits; the link carries four single-bit lines.
package sbr_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int LINK_W   = 4;
    // bit positions of the link lines inside the synchronized vector
    localparam int L_CS     = 0;
    localparam int L_SCK    = 1;
    localparam int L_SDI    = 2;
    localparam int L_SEL    = 3;
    // idle levels taken by the synchronizer during reset
    localparam logic [LINK_W-1:0] LINK_IDLE = 4'b0011;
endpackage

// File: rtl/sbr_sync.sv
// Multi-stage synchronizer for a vector of independent single-bit lines.
// Assumes: each bit is quasi-static relative to clk; reset loads RST_VAL.
module sbr_sync #(
    parameter int            WIDTH   = 4,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // advance one synchronizer stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= RST_VAL;
                else if (s == 0)
                    stage_q[s] <= d_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/sbr_edge.sv
// Rising-edge finder for the synchronized serial clock.
// Assumes: sck_s is already synchronous; reset state treats the line as high
// so that a line sitting high at release does not produce a false edge.
module sbr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic sck_rise
);
    logic sck_prev;

    // remember last synchronized clock level
    always_ff @(posedge clk) begin
        if (!rst_n)
            sck_prev <= 1'b1;
        else
            sck_prev <= sck_s;
    end

    assign sck_rise = sck_s && !sck_prev;

    // two rising edges can never be found in adjacent cycles
    p_rise_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);
endmodule

// File: rtl/sbr_shifter.sv
// Bit counter and shift register: frames bytes MSB first and emits a strobe.
// Assumes: inputs are synchronized and mutually aligned; bit_take pulses at
// most once per serial clock period.
module sbr_shifter
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              bit_take,
    input  logic              sdi_s,
    input  logic              sel_s,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_tag
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_shreg;
    logic              last_take;

    assign next_shreg = {shreg[BYTE_W-2:0], sdi_s};
    assign last_take  = bit_take && !cs_n_s && (bit_cnt == LAST_BIT);

    // count bits of the current byte; chip select high holds it at bit 7
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s)
            bit_cnt <= '0;
        else if (bit_take)
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end

    // shift each sampled data bit in from the low end
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (bit_take && !cs_n_s)
            shreg <= next_shreg;
    end

    // deliver completed byte and tag on a single-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_tag   <= 1'b0;
        end else begin
            out_valid <= last_take;
            if (last_take) begin
                out_byte <= next_shreg;
                out_tag  <= sel_s;
            end
        end
    end

    // chip select high keeps the counter at the first bit
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0));
    // nothing is delivered while chip select is high
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !out_valid);
    // eighth taken bit wraps counter and produces the strobe
    p_wrap_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_take && !cs_n_s && bit_cnt == LAST_BIT) |=> (out_valid && bit_cnt == '0));
    // strobe lasts one cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/serial_byte_rx.sv
// Serial command/data byte receiver top level.
// Assumes: clk is at least 4x the serial clock; rst_n is synchronous active low.
module serial_byte_rx
    import sbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_cs_n,
    input  logic              link_sck,
    input  logic              link_sdi,
    input  logic              link_sel,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_data
);
    logic [LINK_W-1:0] link_raw;
    logic [LINK_W-1:0] link_s;
    logic              sck_rise;

    assign link_raw[L_CS]  = link_cs_n;
    assign link_raw[L_SCK] = link_sck;
    assign link_raw[L_SDI] = link_sdi;
    assign link_raw[L_SEL] = link_sel;

    sbr_sync #(
        .WIDTH   (LINK_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINK_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (link_raw),
        .d_out (link_s)
    );

    sbr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (link_s[L_SCK]),
        .sck_rise (sck_rise)
    );

    sbr_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (link_s[L_CS]),
        .bit_take  (sck_rise),
        .sdi_s     (link_s[L_SDI]),
        .sel_s     (link_s[L_SEL]),
        .out_valid (byte_valid),
        .out_byte  (byte_data),
        .out_tag   (byte_is_data)
    );
endmodule

// File: tb/serial_byte_rx_tb.sv
module serial_byte_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;   // system cycles per serial clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sel = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_is_data;

    int total = 0;
    int bad   = 0;
    int rx_n  = 0;
    int wide  = 0;
    logic [7:0] rx_byte [16];
    logic       rx_tag  [16];
    logic       prev_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_byte_rx dut_i (
        .clk(clk), .rst_n(rst_n), .link_cs_n(cs_n), .link_sck(sck),
        .link_sdi(sdi), .link_sel(sel), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_is_data(byte_is_data)
    );

    // monitor: record delivered bytes away from the active edge
    always @(negedge clk) begin
        if (byte_valid && rx_n < 16) begin
            rx_byte[rx_n] = byte_data;
            rx_tag[rx_n]  = byte_is_data;
            rx_n = rx_n + 1;
        end
        if (byte_valid && prev_valid) wide = wide + 1;
        prev_valid = byte_valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, input logic s);
        sck = 1'b0; sdi = b; sel = s;
        wait_cyc(HALF_BIT);
        sck = 1'b1;
        wait_cyc(HALF_BIT);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic s);
        for (int i = 7; i >= 0; i--) send_bit(v[i], s);
    endtask

    task automatic clear_rx();
        wait_cyc(8);
        rx_n = 0;
        wide = 0;
    endtask

    task automatic t_reset_state();
        wait_cyc(1);
        chk("R9 valid", int'(byte_valid), 0);
        chk("R9 data", int'(byte_data), 0);
        chk("R9 tag", int'(byte_is_data), 0);
    endtask

    task automatic t_single(input logic [7:0] v, input logic s, input string req);
        clear_rx();
        cs_n = 1'b0; wait_cyc(2);
        send_byte(v, s);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk({req, " count"}, rx_n, 1);
        chk({req, " byte"}, int'(rx_byte[0]), int'(v));
        chk({req, " tag"}, int'(rx_tag[0]), int'(s));
        chk("R8 one-cycle strobe", wide, 0);
    endtask

    task automatic t_late_select();
        clear_rx();
        cs_n = 1'b0; wait_cyc(2);
        for (int i = 7; i >= 1; i--) send_bit(1'(8'h5A >> i), 1'b1);
        send_bit(1'b0, 1'b0);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk("R4 count", rx_n, 1);
        chk("R4 tag from eighth edge", int'(rx_tag[0]), 0);
        clear_rx();
        cs_n = 1'b0; wait_cyc(2);
        for (int i = 7; i >= 1; i--) send_bit(1'(8'h5A >> i), 1'b0);
        send_bit(1'b0, 1'b1);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk("R4 tag data at eighth edge", int'(rx_tag[0]), 1);
    endtask

    task automatic t_back_to_back();
        clear_rx();
        cs_n = 1'b0; wait_cyc(2);
        send_byte(8'hC3, 1'b0);
        send_byte(8'h0F, 1'b1);
        send_byte(8'h80, 1'b1);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk("R5 count", rx_n, 3);
        chk("R5 byte0", int'(rx_byte[0]), 8'hC3);
        chk("R5 byte1", int'(rx_byte[1]), 8'h0F);
        chk("R5 byte2", int'(rx_byte[2]), 8'h80);
        chk("R5 tags", {29'd0, rx_tag[0], rx_tag[1], rx_tag[2]}, 3);
        chk("R8 one-cycle strobe back-to-back", wide, 0);
    endtask

    task automatic t_cs_abort();
        clear_rx();
        cs_n = 1'b0; wait_cyc(2);
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(6);
        chk("R6 no partial byte", rx_n, 0);
        cs_n = 1'b0; wait_cyc(2);
        send_byte(8'h81, 1'b0);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk("R6 count", rx_n, 1);
        chk("R6 byte unshifted", int'(rx_byte[0]), 8'h81);
    endtask

    task automatic t_idle_clocks();
        clear_rx();
        cs_n = 1'b1;
        for (int i = 0; i < 12; i++) send_bit(1'(i), 1'b1);
        wait_cyc(6);
        chk("R2 no byte while deselected", rx_n, 0);
        chk("R2 valid low", int'(byte_valid), 0);
        cs_n = 1'b0; wait_cyc(2);
        send_byte(8'h6E, 1'b1);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk("R2 count after select", rx_n, 1);
        chk("R2 byte starts at bit 7", int'(rx_byte[0]), 8'h6E);
    endtask

    task automatic t_reset_abort();
        clear_rx();
        cs_n = 1'b0; wait_cyc(2);
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1);
        rst_n = 1'b0; wait_cyc(4);
        chk("R7 valid low in reset", int'(byte_valid), 0);
        rst_n = 1'b1; wait_cyc(4);
        chk("R7 no partial byte", rx_n, 0);
        send_byte(8'h27, 1'b0);
        wait_cyc(2); cs_n = 1'b1; wait_cyc(8);
        chk("R7 count", rx_n, 1);
        chk("R7 byte after rearm", int'(rx_byte[0]), 8'h27);
        chk("R7 tag", int'(rx_tag[0]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        t_reset_state();
        t_single(8'hA5, 1'b0, "R1 cmd A5");
        t_single(8'h01, 1'b1, "R1 R3 data 01");
        t_single(8'h80, 1'b0, "R1 R3 cmd 80");
        t_late_select();
        t_back_to_back();
        t_cs_abort();
        t_idle_clocks();
        t_reset_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule